// File: doc/BRIEF.md
# Read Latency and Byte-Mask Output Pipeline

This block sits on the data-output side of a synchronous DRAM behavioural model. Each clock edge, the column logic hands it at most one 32-bit word fetched from the array. The block then presents that word on the device data bus after the programmed read latency. A per-lane output-enable stands in for the tri-state drivers. Run-time mode writes can switch the latency between 2 and 3 cycles. All words, including back-to-back words from overlapping bursts, go through one shift chain. The output tap on that chain follows the current latency setting.

There is one byte-mask input for each 8-bit lane, and it is used on both directions. On the read side the mask goes through its own fixed two-cycle delay line and then switches off the lane driver. This delay does not depend on the read latency. On the write side the mask removes the byte enable in the same cycle. A precharge or burst-stop indication (the truncate input) cancels the word entering the pipeline in that cycle. The bus therefore goes quiet exactly one latency period after the truncation. Every input is sampled, and every register updates, on the rising clock edge.

Top module: `sdram_rdpipe`

## Requirements
- R1: With latency 2, a word accepted at rising edge k (rd_vld_i=1, term_i=0) is on dq_o with its lanes enabled after edge k+1, so the bus can sample it at edge k+2.
- R2: With latency 3, a word accepted at edge k is on dq_o after edge k+2.
- R3: The latency register resets to 3. A mode write (mode_set_i=1) with code 2 or 3 on mode_lat_i takes effect from the next edge. The output tap follows the new value at once, including for words already in flight.
- R4: Mask bit i covers lane i, which is dq_o bits [8i+7:8i]. A mask bit sampled at edge k turns off dq_oe_o[i] and zeroes that lane after edge k+1. This delay is the same at either latency.
- R5: term_i sampled at edge k cancels any word offered in that cycle. The slot where that word would have appeared has all lanes disabled, which is latency cycles after the truncation. Words accepted before edge k still appear.
- R6: wr_be_o[i] equals wr_vld_i AND NOT dqm_i[i] in the same cycle, with no register in the path.
- R7: While reset is active, and after reset until a word arrives, all lane enables are low and dq_o is zero.
- R8: A mode write with any code other than 2 or 3 leaves the latency unchanged.
- R9: In every slot that carries no valid word, all lane enables are low and dq_o is zero.
- R10: Words accepted at consecutive edges appear at consecutive edges. This holds when a new burst replaces a burst in flight, with no idle slot between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_set_i | input | 1 | Mode write strobe for the latency field |
| mode_lat_i | input | 2 | Requested read latency (2 or 3; other codes ignored) |
| rd_vld_i | input | 1 | A word from the array is offered this cycle |
| rd_data_i | input | 32 | Word from the array |
| term_i | input | 1 | Precharge or burst-stop: cancel this cycle's word |
| dqm_i | input | 4 | Byte-lane mask, one bit per 8-bit lane |
| wr_vld_i | input | 1 | A write data beat is present this cycle |
| wr_be_o | output | 4 | Write byte enables after same-cycle masking |
| dq_o | output | 32 | Read data bus, zero in undriven lanes |
| dq_oe_o | output | 4 | Per-lane output enable (low models high impedance) |

## Verification
The latency-tap and mask-delay properties use `$past` and fixed delays. They therefore assume that rd_data_i and dqm_i are defined in every cycle after reset. They also assume the latency does not move during the window each property checks. Each property tolerates the other latency setting through an explicit guard on the latency register. The stimulus drives every input to a known value at each falling edge and never leaves them undriven. Mode writes are grouped in short phases, and the directed bursts follow them only after the change has taken effect. The random phase mixes latency switches into running traffic and depends only on the per-cycle reference model, which applies the register value in force at each edge.

// File: rtl/sdram_pipe_pkg.sv
package sdram_pipe_pkg;

   localparam int unsigned DEF_LANES    = 4;
   localparam int unsigned DEF_LANE_W   = 8;
   localparam int unsigned DEF_MIN_LAT  = 2;
   localparam int unsigned DEF_MAX_LAT  = 3;
   localparam int unsigned DEF_MASK_DLY = 2;

   // True when a requested latency code lies in the supported window.
   function automatic logic lat_code_ok(input int unsigned code,
                                        input int unsigned lo,
                                        input int unsigned hi);
      return (code >= lo) && (code <= hi);
   endfunction

endpackage

// File: rtl/stage_chain.sv
// Reset-to-zero shift chain; exposes stages TAP_LO..DEPTH-1 only.
module stage_chain #(
   parameter int unsigned W      = 8,
   parameter int unsigned DEPTH  = 3,
   parameter int unsigned TAP_LO = 0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [W-1:0]                    din,
   output logic [DEPTH-1:TAP_LO][W-1:0]    taps_o
);

   generate
      if (DEPTH < 1 || TAP_LO >= DEPTH) begin : g_bad_cfg
         $error("stage_chain: TAP_LO must lie below DEPTH");
      end
   endgenerate

   logic [DEPTH-1:0][W-1:0] q;

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[s] <= '0;
               else        q[s] <= din;
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[s] <= '0;
               else        q[s] <= q[s-1];
            end
         end
      end
      for (genvar t = TAP_LO; t < DEPTH; t++) begin : g_tap
         assign taps_o[t] = q[t];
      end
   endgenerate

endmodule

// File: rtl/lat_mode_reg.sv
// Holds the active read latency; illegal codes are dropped.
module lat_mode_reg
   import sdram_pipe_pkg::*;
#(
   parameter int unsigned LAT_W   = 2,
   parameter int unsigned MIN_LAT = 2,
   parameter int unsigned MAX_LAT = 3,
   parameter int unsigned RST_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic [LAT_W-1:0] code_i,
   output logic [LAT_W-1:0] lat_o
);

   generate
      if (RST_LAT < MIN_LAT || RST_LAT > MAX_LAT) begin : g_bad_rst
         $error("lat_mode_reg: reset latency outside legal window");
      end
   endgenerate

   logic accept;
   assign accept = set_i && lat_code_ok(int'(code_i), MIN_LAT, MAX_LAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_o <= LAT_W'(RST_LAT);
      else if (accept) lat_o <= code_i;
   end

endmodule

// File: rtl/wr_mask_gate.sv
// Zero-delay write-side byte masking.
module wr_mask_gate #(
   parameter int unsigned LANES = 4
) (
   input  logic             wr_vld_i,
   input  logic [LANES-1:0] dqm_i,
   output logic [LANES-1:0] wr_be_o
);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign wr_be_o[g] = wr_vld_i & ~dqm_i[g];
      end
   endgenerate

endmodule

// File: rtl/sdram_rdpipe.sv
module sdram_rdpipe
   import sdram_pipe_pkg::*;
#(
   parameter int unsigned LANES    = DEF_LANES,
   parameter int unsigned LANE_W   = DEF_LANE_W,
   parameter int unsigned MIN_LAT  = DEF_MIN_LAT,
   parameter int unsigned MAX_LAT  = DEF_MAX_LAT,
   parameter int unsigned MASK_DLY = DEF_MASK_DLY,
   parameter int unsigned RST_LAT  = DEF_MAX_LAT,
   localparam int unsigned DATA_W  = LANES * LANE_W,
   localparam int unsigned LAT_W   = $clog2(MAX_LAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_set_i,
   input  logic [LAT_W-1:0]  mode_lat_i,
   input  logic              rd_vld_i,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              term_i,
   input  logic [LANES-1:0]  dqm_i,
   input  logic              wr_vld_i,
   output logic [LANES-1:0]  wr_be_o,
   output logic [DATA_W-1:0] dq_o,
   output logic [LANES-1:0]  dq_oe_o
);

   localparam int unsigned ENT_W = DATA_W + 1;

   generate
      if (MIN_LAT < 1 || MAX_LAT < MIN_LAT) begin : g_bad_lat
         $error("sdram_rdpipe: latency window is empty");
      end
      if (MASK_DLY < 1) begin : g_bad_mask
         $error("sdram_rdpipe: mask delay must be at least one cycle");
      end
   endgenerate

   // ---------------- latency mode ----------------
   logic [LAT_W-1:0] lat_q;

   lat_mode_reg #(
      .LAT_W   (LAT_W),
      .MIN_LAT (MIN_LAT),
      .MAX_LAT (MAX_LAT),
      .RST_LAT (RST_LAT)
   ) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (mode_set_i),
      .code_i (mode_lat_i),
      .lat_o  (lat_q)
   );

   // ---------------- read word chain ----------------
   logic [ENT_W-1:0]                  rd_ent;
   logic [MAX_LAT-1:MIN_LAT-1][ENT_W-1:0] rd_taps;

   assign rd_ent = {rd_vld_i & ~term_i, rd_data_i};

   stage_chain #(
      .W      (ENT_W),
      .DEPTH  (MAX_LAT),
      .TAP_LO (MIN_LAT - 1)
   ) u_rd_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (rd_ent),
      .taps_o (rd_taps)
   );

   logic [ENT_W-1:0] sel_ent;

   always_comb begin
      sel_ent = '0;
      for (int l = MIN_LAT; l <= MAX_LAT; l++) begin
         if (lat_q == LAT_W'(l)) sel_ent = rd_taps[l-1];
      end
   end

   logic              sel_vld;
   logic [DATA_W-1:0] sel_dat;
   assign sel_vld = sel_ent[ENT_W-1];
   assign sel_dat = sel_ent[DATA_W-1:0];

   // ---------------- read mask delay ----------------
   logic [MASK_DLY-1:MASK_DLY-1][LANES-1:0] mask_tap;

   stage_chain #(
      .W      (LANES),
      .DEPTH  (MASK_DLY),
      .TAP_LO (MASK_DLY - 1)
   ) u_mask_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (dqm_i),
      .taps_o (mask_tap)
   );

   // ---------------- lane drivers ----------------
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign dq_oe_o[g] = sel_vld & ~mask_tap[MASK_DLY-1][g];
         assign dq_o[g*LANE_W +: LANE_W] =
            dq_oe_o[g] ? sel_dat[g*LANE_W +: LANE_W] : '0;
      end
   endgenerate

   // ---------------- write side ----------------
   wr_mask_gate #(
      .LANES (LANES)
   ) u_wr_gate (
      .wr_vld_i (wr_vld_i),
      .dqm_i    (dqm_i),
      .wr_be_o  (wr_be_o)
   );

endmodule

// File: rtl/sdram_rdpipe_chk.sv
module sdram_rdpipe_chk #(
   parameter int unsigned LANES    = 4,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned MIN_LAT  = 2,
   parameter int unsigned MAX_LAT  = 3,
   parameter int unsigned MASK_DLY = 2,
   parameter int unsigned LAT_W    = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      mode_set_i,
   input logic [LAT_W-1:0]          mode_lat_i,
   input logic                      rd_vld_i,
   input logic [LANES*LANE_W-1:0]   rd_data_i,
   input logic                      term_i,
   input logic [LANES-1:0]          dqm_i,
   input logic                      wr_vld_i,
   input logic [LANES-1:0]          wr_be_o,
   input logic [LANES*LANE_W-1:0]   dq_o,
   input logic [LANES-1:0]          dq_oe_o,
   input logic [LAT_W-1:0]          lat_q
);

   logic [LANES*LANE_W-1:0] oe_bits;
   for (genvar g = 0; g < LANES; g++) begin : g_exp
      assign oe_bits[g*LANE_W +: LANE_W] = {LANE_W{dq_oe_o[g]}};
   end

   logic bad_code;
   assign bad_code = (int'(mode_lat_i) < MIN_LAT) || (int'(mode_lat_i) > MAX_LAT);

   // R1
   min_lat_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_i && !term_i) |-> ##MIN_LAT
      (lat_q != LAT_W'(MIN_LAT) ||
       ((dq_o ^ $past(rd_data_i, MIN_LAT)) & oe_bits) == '0));

   // R2
   max_lat_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_i && !term_i) |-> ##MAX_LAT
      (lat_q != LAT_W'(MAX_LAT) ||
       ((dq_o ^ $past(rd_data_i, MAX_LAT)) & oe_bits) == '0));

   // R3
   lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_set_i && !bad_code) |=> (lat_q == $past(mode_lat_i)));

   // R4
   mask_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dqm_i != '0) |-> ##MASK_DLY ((dq_oe_o & $past(dqm_i, MASK_DLY)) == '0));

   // R5
   term_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_i |-> ##MIN_LAT (lat_q != LAT_W'(MIN_LAT) || dq_oe_o == '0));

   // R5
   term_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_i |-> ##MAX_LAT (lat_q != LAT_W'(MAX_LAT) || dq_oe_o == '0));

   // R6
   wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_be_o & dqm_i) == '0) && (wr_vld_i || wr_be_o == '0));

   // R8
   bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_set_i && bad_code) |=> $stable(lat_q));

   // R9
   quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_o & ~oe_bits) == '0);

endmodule

bind sdram_rdpipe sdram_rdpipe_chk #(
   .LANES    (LANES),
   .LANE_W   (LANE_W),
   .MIN_LAT  (MIN_LAT),
   .MAX_LAT  (MAX_LAT),
   .MASK_DLY (MASK_DLY),
   .LAT_W    (LAT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_set_i (mode_set_i),
   .mode_lat_i (mode_lat_i),
   .rd_vld_i   (rd_vld_i),
   .rd_data_i  (rd_data_i),
   .term_i     (term_i),
   .dqm_i      (dqm_i),
   .wr_vld_i   (wr_vld_i),
   .wr_be_o    (wr_be_o),
   .dq_o       (dq_o),
   .dq_oe_o    (dq_oe_o),
   .lat_q      (lat_q)
);

// File: tb/sdram_rdpipe_tb.sv
module sdram_rdpipe_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_set_i = 1'b0;
   logic [1:0]  mode_lat_i = 2'd0;
   logic        rd_vld_i = 1'b0;
   logic [31:0] rd_data_i = '0;
   logic        term_i = 1'b0;
   logic [3:0]  dqm_i = '0;
   logic        wr_vld_i = 1'b0;
   logic [3:0]  wr_be_o;
   logic [31:0] dq_o;
   logic [3:0]  dq_oe_o;

   sdram_rdpipe u_dut (
      .clk(clk), .rst_n(rst_n), .mode_set_i(mode_set_i), .mode_lat_i(mode_lat_i),
      .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i), .term_i(term_i), .dqm_i(dqm_i),
      .wr_vld_i(wr_vld_i), .wr_be_o(wr_be_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
   );

   always #10 clk = ~clk;   // 50 MHz

   int    checks = 0;
   int    failures = 0;
   int    n = 0;            // rising edges so far
   string tag = "R7";
   bit    done = 0;

   // history of what was sampled at each edge (ring of 64)
   bit          hv [64];
   logic [31:0] hd [64];
   logic [3:0]  hm [64];
   int          hl [64];

   task automatic fail_line(string r, string what, logic [31:0] act, logic [31:0] exp);
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
   endtask

   task automatic compare();
      int          l;
      int          e;
      logic [3:0]  exp_oe;
      logic [31:0] exp_dq;
      l = hl[n % 64];
      e = (n - l + 1) % 64;
      for (int g = 0; g < 4; g++) begin
         exp_oe[g] = hv[e] & ~hm[(n - 1) % 64][g];
         exp_dq[g*8 +: 8] = exp_oe[g] ? hd[e][g*8 +: 8] : 8'h00;
      end
      checks++;
      if (dq_oe_o !== exp_oe) fail_line(tag, "dq_oe_o", {28'd0, dq_oe_o}, {28'd0, exp_oe});
      checks++;
      if (dq_o !== exp_dq) fail_line(tag, "dq_o", dq_o, exp_dq);
   endtask

   // Drive one cycle's inputs, record them, pass one edge, check at the falling edge.
   task automatic cyc(input bit vld, input logic [31:0] dat, input bit trm,
                      input logic [3:0] msk, input bit mset, input logic [1:0] mcode,
                      input bit wvld);
      int nx;
      logic [3:0] exp_be;
      rd_vld_i = vld; rd_data_i = dat; term_i = trm; dqm_i = msk;
      mode_set_i = mset; mode_lat_i = mcode; wr_vld_i = wvld;
      #1;
      exp_be = wvld ? ~msk : 4'h0;
      checks++;
      if (wr_be_o !== exp_be) fail_line("R6", "wr_be_o", {28'd0, wr_be_o}, {28'd0, exp_be});
      nx = (n + 1) % 64;
      if (!rst_n) begin
         hv[nx] = 0; hd[nx] = '0; hm[nx] = '0; hl[nx] = 3;
      end else begin
         hv[nx] = vld & ~trm; hd[nx] = dat; hm[nx] = msk;
         hl[nx] = (mset && (mcode == 2'd2 || mcode == 2'd3)) ? int'(mcode) : hl[n % 64];
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n >= 3) compare();
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) cyc(0, $urandom, 0, 4'h0, 0, 2'd0, 0);
   endtask

   task automatic burst(input int k, input logic [31:0] base);
      for (int i = 0; i < k; i++) cyc(1, base + 32'h01010101 * i, 0, 4'h0, 0, 2'd0, 0);
   endtask

   task automatic set_lat(input logic [1:0] code);
      cyc(0, '0, 0, 4'h0, 1, code, 0);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         hv[i] = 0; hd[i] = '0; hm[i] = '0; hl[i] = 3;
      end
      @(negedge clk);
      // R7: reset holds the bus quiet even with traffic offered
      tag = "R7";
      for (int i = 0; i < 4; i++) cyc(1, 32'hDEAD0000 + i, 0, 4'h0, 0, 2'd0, 0);
      rst_n = 1'b1;
      idle(3);
      // R2: reset latency is 3
      tag = "R2";
      burst(8, 32'h10203040);
      idle(4);
      // R3 then R1: switch to latency 2
      tag = "R3";
      set_lat(2'd2);
      tag = "R1";
      burst(8, 32'hA0B0C0D0);
      idle(4);
      // R10: a new burst replaces the running one with no gap
      tag = "R10";
      burst(4, 32'h11111111);
      burst(4, 32'h77777777);
      idle(3);
      // R4: read masks at latency 2 and 3
      tag = "R4";
      for (int i = 0; i < 10; i++) cyc(1, $urandom, 0, 4'($urandom), 0, 2'd0, 0);
      idle(3);
      set_lat(2'd3);
      for (int i = 0; i < 10; i++) cyc(1, $urandom, 0, 4'($urandom), 0, 2'd0, 0);
      idle(4);
      // R5: truncation at latency 3, then at latency 2
      tag = "R5";
      burst(3, 32'h50505050);
      cyc(1, 32'hBADBAD00, 1, 4'h0, 0, 2'd0, 0);
      idle(4);
      set_lat(2'd2);
      burst(3, 32'h60606060);
      cyc(0, '0, 1, 4'h0, 0, 2'd0, 0);
      burst(2, 32'h61616161);
      idle(4);
      // R8: illegal codes leave latency 2 in force
      tag = "R8";
      set_lat(2'd0);
      set_lat(2'd1);
      burst(5, 32'h80808080);
      idle(4);
      // R9: nothing valid, random data must not leak
      tag = "R9";
      for (int i = 0; i < 6; i++) cyc(0, $urandom, 0, 4'($urandom), 0, 2'd0, 0);
      // R6: writes with masks
      tag = "R6";
      for (int i = 0; i < 8; i++) cyc(0, '0, 0, 4'($urandom), 0, 2'd0, 1);
      // mixed traffic with latency switches in flight
      tag = "R3";
      for (int i = 0; i < 400; i++) begin
         cyc(($urandom % 4) != 0, $urandom, ($urandom % 9) == 0, 4'($urandom % 3 == 0 ? $urandom : 0),
             ($urandom % 17) == 0, 2'($urandom), $urandom % 2);
      end
      idle(4);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule